// File: doc/BRIEF.md
# Interprocessor Destination Resolver

This block takes one interprocessor interrupt command and works out which of N targets it reaches. A command carries a destination byte, a physical/logical mode bit, a two-bit shorthand, a delivery mode and the index of the sending target. Each target supplies its 8-bit physical ID, its 8-bit logical ID, a 2-bit logical format code and an enabled flag. On a command strobe, the block evaluates every target's address match in parallel. One clock later it presents the result.

For ordinary delivery modes the result is the full match mask. For lowest-priority delivery the block instead grants exactly one target. It takes the first target that is both matched and enabled, starting just after the previously granted target and wrapping around. The round-robin pointer survives from one command to the next. The block does not model the command register or the acceptance logic inside each target.

Top module: `ipi_dest_resolver`

## Requirements
- R1: After reset `res_valid` is 0 and `res_mask` is 0. `res_valid` is 1 in exactly the cycle after each cycle with `cmd_valid` high, and 0 otherwise. `res_mask` is updated in that same cycle.
- R2: With shorthand 0 and `cmd_logical`=0, a target matches when `cmd_dest` equals its physical ID, or when `cmd_dest` is 0xFF.
- R3: With shorthand 0, `cmd_logical`=1 and a target format code of 2'b11 (flat), the target matches when the bitwise AND of its logical ID and `cmd_dest` is nonzero.
- R4: With shorthand 0, `cmd_logical`=1 and a target format code of 2'b00 (cluster), the target matches when bits 7:4 of its logical ID equal bits 7:4 of `cmd_dest` and the AND of bits 3:0 of the two is nonzero.
- R5: With shorthand 0 and `cmd_logical`=1, a target whose format code is 2'b01 or 2'b10 never matches, even for destination 0xFF.
- R6: Shorthand 1 matches only the target at index `cmd_src`. Shorthand 2 matches every target. Shorthand 3 matches every target except `cmd_src`. For shorthands 1 to 3, `cmd_dest` and `cmd_logical` have no effect.
- R7: For every delivery mode other than 3'b001, `res_mask` is the full match mask, whatever the enabled flags are. The round-robin pointer is left unchanged.
- R8: For delivery mode 3'b001 (lowest priority), `res_mask` is one-hot. It selects the first target that is both matched and enabled, searching from pointer+1 upward and wrapping from N-1 to 0. The pointer's own target is examined last.
- R9: A lowest-priority grant moves the pointer to the granted index. The pointer resets to 0, so the first search after reset begins at target 1.
- R10: When no target is both matched and enabled, a lowest-priority command yields an all-zero `res_mask` and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_dest | input | 8 | Destination byte |
| cmd_logical | input | 1 | 0 selects physical addressing, 1 selects logical addressing |
| cmd_short | input | 2 | Shorthand: 0 uses destination, 1 self, 2 all, 3 all but self |
| cmd_dmode | input | 3 | Delivery mode; 3'b001 is lowest priority |
| cmd_src | input | IDX_W | Index of the sending target |
| tgt_id | input | 8*N | Physical IDs, target i in bits 8i+7:8i |
| tgt_lid | input | 8*N | Logical IDs, same packing |
| tgt_fmt | input | 2*N | Logical format codes, target i in bits 2i+1:2i |
| tgt_en | input | N | Per-target enabled flags |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_mask | output | N | Match mask, or the one-hot lowest-priority grant |

## Verification
The hardest situation to reach is the round-robin pointer state. It cannot be read at the ports and shows up only through later grants. The stimulus therefore chains lowest-priority commands whose candidate sets are shaped with the enabled flags and logical IDs. These sequences force a wrap past N-1, make the pointer's own target the only candidate, and produce an empty search. Fixed-mode commands are placed between the lowest-priority commands. The next grant then shows whether the pointer moved when it should not have.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    SH_DEST     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL      = 2'd2,
    SH_ALL_XSELF = 2'd3
  } shorthand_e;

  localparam logic [2:0] DM_LOWPRI    = 3'b001;
  localparam logic [1:0] FMT_FLAT     = 2'b11;
  localparam logic [1:0] FMT_CLUSTER  = 2'b00;
  localparam logic [7:0] DEST_BCAST   = 8'hFF;

endpackage

// File: rtl/ipi_addr_match.sv
module ipi_addr_match
  import ipi_pkg::*;
(
  input  logic [7:0] dest,
  input  logic       logical,
  input  logic [1:0] shorthand,
  input  logic       is_sender,
  input  logic [7:0] phys_id,
  input  logic [7:0] log_id,
  input  logic [1:0] fmt,
  output logic       hit
);

  logic phys_hit;
  logic flat_hit;
  logic clus_hit;
  logic addr_hit;

  always_comb begin
    phys_hit = (dest == DEST_BCAST) || (dest == phys_id);
    flat_hit = (log_id & dest) != 8'h00;
    clus_hit = (log_id[7:4] == dest[7:4]) && ((log_id[3:0] & dest[3:0]) != 4'h0);
    if (!logical)              addr_hit = phys_hit;
    else if (fmt == FMT_FLAT)  addr_hit = flat_hit;
    else if (fmt == FMT_CLUSTER) addr_hit = clus_hit;
    else                       addr_hit = 1'b0;

    unique case (shorthand_e'(shorthand))
      SH_DEST:      hit = addr_hit;
      SH_SELF:      hit = is_sender;
      SH_ALL:       hit = 1'b1;
      SH_ALL_XSELF: hit = !is_sender;
      default:      hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] ptr,
  output logic [N-1:0]     grant,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    grant = '0;
    found = 1'b0;
    idx   = ptr;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!found && cand[j]) begin
        found    = 1'b1;
        grant[j] = 1'b1;
        idx      = IDX_W'(j);
      end
    end
  end

  // R8: a grant never lands on a target outside the candidate set
  always_comb begin
    a_grant_in_cand_r8: assert ((grant & ~cand) == '0);
  end

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_dest,
  input  logic             cmd_logical,
  input  logic [1:0]       cmd_short,
  input  logic [2:0]       cmd_dmode,
  input  logic [IDX_W-1:0] cmd_src,
  input  logic [8*N-1:0]   tgt_id,
  input  logic [8*N-1:0]   tgt_lid,
  input  logic [2*N-1:0]   tgt_fmt,
  input  logic [N-1:0]     tgt_en,
  output logic             res_valid,
  output logic [N-1:0]     res_mask
);

  logic [N-1:0]     match_vec;
  logic [N-1:0]     pick_grant;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             is_lowpri;

  logic             valid_q, valid_d;
  logic [N-1:0]     mask_q, mask_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             lowpri_q, lowpri_d;

  for (genvar g = 0; g < N; g++) begin : g_tgt
    ipi_addr_match u_match (
      .dest      (cmd_dest),
      .logical   (cmd_logical),
      .shorthand (cmd_short),
      .is_sender (cmd_src == IDX_W'(g)),
      .phys_id   (tgt_id[8*g +: 8]),
      .log_id    (tgt_lid[8*g +: 8]),
      .fmt       (tgt_fmt[2*g +: 2]),
      .hit       (match_vec[g])
    );
  end

  ipi_rr_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .cand  (match_vec & tgt_en),
    .ptr   (ptr_q),
    .grant (pick_grant),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign is_lowpri = (cmd_dmode == DM_LOWPRI);

  always_comb begin
    valid_d  = cmd_valid;
    mask_d   = mask_q;
    ptr_d    = ptr_q;
    lowpri_d = lowpri_q;
    if (cmd_valid) begin
      lowpri_d = is_lowpri;
      if (is_lowpri) begin
        mask_d = pick_grant;
        if (pick_found) ptr_d = pick_idx;
      end else begin
        mask_d = match_vec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      mask_q   <= '0;
      ptr_q    <= '0;
      lowpri_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (cmd_valid) begin
        mask_q   <= mask_d;
        ptr_q    <= ptr_d;
        lowpri_q <= lowpri_d;
      end
    end
  end

  assign res_valid = valid_q;
  assign res_mask  = mask_q;

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> res_valid);

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && lowpri_q) |-> $onehot0(res_mask));

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !is_lowpri) |=> $stable(ptr_q));

  p_ptr_at_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && lowpri_q && res_mask != '0) |-> res_mask[ptr_q]);

  p_empty_keeps_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_lowpri && (match_vec & tgt_en) == '0) |=> $stable(ptr_q));

endmodule

// File: tb/ipi_dest_resolver_tb_top.sv
module ipi_dest_resolver_tb_top;

  localparam int N     = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_valid;
  logic [7:0]       cmd_dest;
  logic             cmd_logical;
  logic [1:0]       cmd_short;
  logic [2:0]       cmd_dmode;
  logic [IDX_W-1:0] cmd_src;
  logic [8*N-1:0]   tgt_id;
  logic [8*N-1:0]   tgt_lid;
  logic [2*N-1:0]   tgt_fmt;
  logic [N-1:0]     tgt_en;
  logic             res_valid;
  logic [N-1:0]     res_mask;

  logic [7:0] m_id  [N];
  logic [7:0] m_lid [N];
  logic [1:0] m_fmt [N];
  logic       m_en  [N];
  int         m_ptr;

  logic [N-1:0] exp_q [$];
  string        tag_q [$];
  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  ipi_dest_resolver #(.N(N), .IDX_W(IDX_W)) dut_i (
    .clk, .rst_n, .cmd_valid, .cmd_dest, .cmd_logical, .cmd_short,
    .cmd_dmode, .cmd_src, .tgt_id, .tgt_lid, .tgt_fmt, .tgt_en,
    .res_valid, .res_mask
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tgt_id[8*i +: 8]  = m_id[i];
      tgt_lid[8*i +: 8] = m_lid[i];
      tgt_fmt[2*i +: 2] = m_fmt[i];
      tgt_en[i]         = m_en[i];
    end
  end

  function automatic logic [N-1:0] model_match(logic [7:0] d, logic lg, logic [1:0] sh, int src);
    logic [N-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++) begin
      case (sh)
        2'd1: m[i] = (i == src);
        2'd2: m[i] = 1'b1;
        2'd3: m[i] = (i != src);
        default: begin
          if (!lg)                  m[i] = (d == 8'hFF) || (d == m_id[i]);
          else if (m_fmt[i] == 2'b11) m[i] = (m_lid[i] & d) != 0;
          else if (m_fmt[i] == 2'b00) m[i] = (m_lid[i][7:4] == d[7:4]) && ((m_lid[i][3:0] & d[3:0]) != 0);
          else                      m[i] = 1'b0;
        end
      endcase
    end
    return m;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send(string tag, logic [7:0] d, logic lg, logic [1:0] sh, logic [2:0] dm, int src);
    logic [N-1:0] m, e;
    @(negedge clk);
    m = model_match(d, lg, sh, src);
    if (dm == 3'b001) begin
      e = '0;
      for (int k = 1; k <= N; k++) begin
        int j;
        j = (m_ptr + k) % N;
        if (e == '0 && m[j] && m_en[j]) begin
          e[j] = 1'b1;
          m_ptr = j;
        end
      end
    end else begin
      e = m;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cmd_dest = d; cmd_logical = lg; cmd_short = sh; cmd_dmode = dm;
    cmd_src = IDX_W'(src); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Monitor: scoreboard comparison one ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R1: res_valid high with no command, actual 1 expected 0");
        end else begin
          logic [N-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, res_mask, e);
        end
      end else if (exp_q.size() != 0) begin
        n_checks++; n_fail++;
        $display("FAIL R1: res_valid low with pending result, actual 0 expected 1");
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_dest = '0; cmd_logical = 1'b0;
    cmd_short = '0; cmd_dmode = '0; cmd_src = '0; m_ptr = 0;
    for (int i = 0; i < N; i++) begin
      m_id[i] = 8'h10 + 8'(i); m_lid[i] = 8'(1 << i); m_fmt[i] = 2'b11; m_en[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    check("R1 reset valid", N'(res_valid), '0);
    check("R1 reset mask", res_mask, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send("R2 physical id", 8'h13, 0, 2'd0, 3'b000, 0);
    send("R2 physical bcast", 8'hFF, 0, 2'd0, 3'b000, 0);
    send("R2 physical none", 8'h55, 0, 2'd0, 3'b000, 0);
    send("R3 flat", 8'h05, 1, 2'd0, 3'b000, 0);
    send("R3 flat bcast", 8'hFF, 1, 2'd0, 3'b000, 0);
    for (int i = 0; i < N; i++) begin
      m_fmt[i] = 2'b00; m_lid[i] = {4'(i / 4), 4'(1 << (i % 4))};
    end
    send("R4 cluster", 8'h13, 1, 2'd0, 3'b000, 0);
    send("R4 cluster miss", 8'h23, 1, 2'd0, 3'b000, 0);
    m_fmt[4] = 2'b01; m_fmt[5] = 2'b10;
    send("R5 bad format", 8'h13, 1, 2'd0, 3'b000, 0);
    for (int i = 0; i < N; i++) m_fmt[i] = 2'b10;
    send("R5 bad format bcast", 8'hFF, 1, 2'd0, 3'b000, 0);
    send("R6 self", 8'h00, 1, 2'd1, 3'b000, 5);
    send("R6 all", 8'h00, 1, 2'd2, 3'b000, 5);
    send("R6 all but self", 8'h13, 0, 2'd3, 3'b000, 5);
    send("R6 self dest ignored", 8'h10, 0, 2'd1, 3'b000, 2);
    m_en[3] = 1'b0; m_en[6] = 1'b0;
    send("R7 fixed ignores enable", 8'hFF, 0, 2'd0, 3'b100, 0);
    for (int i = 0; i < N; i++) m_en[i] = 1'b1;
    send("R8 R9 first grant", 8'hFF, 0, 2'd0, 3'b001, 0);
    send("R8 R9 second grant", 8'hFF, 0, 2'd0, 3'b001, 0);
    send("R7 fixed between", 8'hFF, 0, 2'd2, 3'b000, 0);
    send("R8 after fixed", 8'hFF, 0, 2'd2, 3'b001, 0);
    m_en[4] = 1'b0; m_en[5] = 1'b0;
    send("R8 skip disabled", 8'hFF, 0, 2'd0, 3'b001, 0);
    send("R8 wrap", 8'h11, 0, 2'd0, 3'b001, 0);
    send("R8 pointer target last", 8'h11, 0, 2'd0, 3'b001, 0);
    m_en[1] = 1'b0;
    send("R10 none qualifies", 8'h11, 0, 2'd0, 3'b001, 0);
    for (int i = 0; i < N; i++) m_en[i] = 1'b1;
    send("R10 pointer kept", 8'hFF, 0, 2'd0, 3'b001, 0);
    send("R8 self shorthand lowpri", 8'h00, 0, 2'd3, 3'b001, 3);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule